// File: doc/BRIEF.md
# Segmented Scan Chain with Per-Segment Shift Enables

This block is a scan chain cut into a number of equal-length segments. All segments share one serial scan input, one test-mode select and one functional capture path. A one-hot segment-enable vector, produced by a separate controller, picks the single segment that accepts serial data during a shift cycle. The segment order is therefore set by whatever sequence the controller applies, and the shifted pattern is unreadable to anyone who does not know it.

Disabled segments never fall into functional capture while the test mode select is high. A parameter picks one of two ways to keep them intact. In the recirculating variant every segment shifts each test cycle, and a disabled segment feeds its own tail bit back into its head, so after a whole segment length of cycles it holds its original contents again. In the hold variant a disabled segment keeps its state through a synchronous shift enable. No clock gating is used. With the test mode select low, every cell loads its functional input in one cycle. The serial output is the tail cell of the enabled segment, so the previous response leaves the chain while the next pattern enters it.

Top module: `seg_scan_chain`

## Requirements
- R1: While rst_ni is low, every cell clears to 0, and cell_q_o reads all zeros after reset.
- R2: With test_en_i low, every cell loads its func_d_i bit on the next clock edge, whatever the value of seg_en_i.
- R3: With test_en_i high and seg_en_i bit s set, segment s shifts toward its tail. Its head cell takes scan_in_i and cell c+1 takes the old value of cell c.
- R4: In the recirculating variant (VARIANT = VAR_FEEDBACK), a disabled segment in test mode rotates by one place per cycle, and its head takes its own tail. After SEG_LEN such cycles its contents equal the original.
- R5: In the hold variant (VARIANT = VAR_GATED), a disabled segment in test mode keeps its contents unchanged.
- R6: In test mode, scan_out_o equals the tail cell of the segment selected by a one-hot seg_en_i. It is 0 when seg_en_i is all zeros. In test mode, seg_en_i must be one-hot or zero.
- R7: Suppose each segment is enabled for exactly SEG_LEN cycles, in a known order. Then the bits seen on scan_out_o are the previously captured data, taken segment by segment in that order with the tail cell first. At the same time, the chain ends up holding the newly shifted pattern.
- R8: Cell c of segment s (c = 0 is the head, c = SEG_LEN-1 is the tail) sits at bit s*SEG_LEN+c of cell_q_o and takes its functional input from the same bit of func_d_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| test_en_i | input | 1 | 1: shift mode, 0: functional capture |
| seg_en_i | input | NUM_SEG | One-hot segment shift enable |
| scan_in_i | input | 1 | Shared serial scan input |
| func_d_i | input | NUM_SEG*SEG_LEN | Functional data into the cells |
| cell_q_o | output | NUM_SEG*SEG_LEN | Cell contents toward the logic under test |
| scan_out_o | output | 1 | Tail cell of the enabled segment |

## Verification
The condition that is hardest to reach from the ports is a disabled segment caught part-way through a rotation. A full-length enable window hides the recirculation completely, because the segment comes back unchanged. So the stimulus enables one segment for only three cycles after a known capture, and then compares the other segments of both variants: they must be rotated in one variant and untouched in the other. A shift cycle with no segment enabled also exposes one-place rotation across all segments. A full unload in a scrambled segment order then checks that the serial stream is the captured data permuted by that order, while the new pattern lands in place.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
  typedef enum logic {
    VAR_FEEDBACK = 1'b0,
    VAR_GATED    = 1'b1
  } variant_e;
endpackage

// File: rtl/seg_scan_subchain.sv
module seg_scan_subchain
  import seg_scan_pkg::*;
#(
  parameter int       SEG_LEN = 8,
  parameter variant_e VARIANT = VAR_FEEDBACK
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               test_en_i,
  input  logic               seg_en_i,
  input  logic               scan_in_i,
  input  logic [SEG_LEN-1:0] func_d_i,
  output logic [SEG_LEN-1:0] cell_q_o,
  output logic               tail_o
);
  localparam int TAIL = SEG_LEN - 1;

  logic [SEG_LEN-1:0] cell_q;
  logic [SEG_LEN-1:0] shift_val;
  logic [SEG_LEN-1:0] idle_val;
  logic [SEG_LEN-1:0] cell_d;

  assign shift_val = {cell_q[TAIL-1:0], scan_in_i};

  generate
    if (VARIANT == VAR_FEEDBACK) begin : g_fb
      // disabled segment recirculates its own tail
      assign idle_val = {cell_q[TAIL-1:0], cell_q[TAIL]};
    end else begin : g_hold
      // synchronous shift enable stands in for clock gating
      assign idle_val = cell_q;
    end
  endgenerate

  // enable never acts as a local test select
  always_comb begin
    if (!test_en_i)    cell_d = func_d_i;
    else if (seg_en_i) cell_d = shift_val;
    else               cell_d = idle_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cell_q <= '0;
    else         cell_q <= cell_d;
  end

  assign cell_q_o = cell_q;
  assign tail_o   = cell_q[TAIL];

  // R2
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_en_i |=> cell_q_o == $past(func_d_i));

  // R3
  shift_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && seg_en_i) |=> cell_q_o[0] == $past(scan_in_i));

  // R3
  shift_body_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && seg_en_i) |=> cell_q_o[TAIL:1] == $past(cell_q_o[TAIL-1:0]));

  generate
    if (VARIANT == VAR_FEEDBACK) begin : g_fb_chk
      // R4
      recirc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (test_en_i && !seg_en_i) |=> cell_q_o[0] == $past(tail_o));
    end else begin : g_hold_chk
      // R5
      hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (test_en_i && !seg_en_i) |=> $stable(cell_q_o));
    end
  endgenerate
endmodule

// File: rtl/seg_scan_out_sel.sv
module seg_scan_out_sel #(
  parameter int NUM_SEG = 4
) (
  input  logic [NUM_SEG-1:0] sel_i,
  input  logic [NUM_SEG-1:0] tail_i,
  output logic               so_o
);
  // one-hot AND-OR select, zero when nothing enabled
  assign so_o = |(sel_i & tail_i);
endmodule

// File: rtl/seg_scan_chain.sv
module seg_scan_chain
  import seg_scan_pkg::*;
#(
  parameter int       NUM_SEG = 4,
  parameter int       SEG_LEN = 8,
  parameter variant_e VARIANT = VAR_FEEDBACK
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       test_en_i,
  input  logic [NUM_SEG-1:0]         seg_en_i,
  input  logic                       scan_in_i,
  input  logic [NUM_SEG*SEG_LEN-1:0] func_d_i,
  output logic [NUM_SEG*SEG_LEN-1:0] cell_q_o,
  output logic                       scan_out_o
);
  localparam int CHAIN_LEN = NUM_SEG * SEG_LEN;

  logic [NUM_SEG-1:0] tail;

  generate
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      seg_scan_subchain #(
        .SEG_LEN (SEG_LEN),
        .VARIANT (VARIANT)
      ) u_sub (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .test_en_i (test_en_i),
        .seg_en_i  (seg_en_i[s]),
        .scan_in_i (scan_in_i),
        .func_d_i  (func_d_i[s*SEG_LEN +: SEG_LEN]),
        .cell_q_o  (cell_q_o[s*SEG_LEN +: SEG_LEN]),
        .tail_o    (tail[s])
      );

      // R6
      so_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (test_en_i && seg_en_i == NUM_SEG'(1) << s) |->
          scan_out_o == cell_q_o[s*SEG_LEN + SEG_LEN - 1]);
    end
  endgenerate

  seg_scan_out_sel #(.NUM_SEG(NUM_SEG)) u_out_sel (
    .sel_i  (seg_en_i),
    .tail_i (tail),
    .so_o   (scan_out_o)
  );

  // R6
  en_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_en_i |-> $onehot0(seg_en_i));

  // R6
  so_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && seg_en_i == '0) |-> !scan_out_o);

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> cell_q_o == CHAIN_LEN'(0));
endmodule

// File: tb/seg_scan_chain_bench.sv
`timescale 1ns/1ps
module seg_scan_chain_bench;
  import seg_scan_pkg::*;

  localparam int NS = 4;
  localparam int SL = 8;
  localparam int N  = NS * SL;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          test_en_i = 1'b0;
  logic [NS-1:0] seg_en_i = '0;
  logic          scan_in_i = 1'b0;
  logic [N-1:0]  func_d_i = '0;
  logic [N-1:0]  q_fb, q_g;
  logic          so_fb, so_g;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  seg_scan_chain #(.NUM_SEG(NS), .SEG_LEN(SL), .VARIANT(VAR_FEEDBACK)) u_seg_scan_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .test_en_i(test_en_i), .seg_en_i(seg_en_i),
    .scan_in_i(scan_in_i), .func_d_i(func_d_i), .cell_q_o(q_fb), .scan_out_o(so_fb));

  seg_scan_chain #(.NUM_SEG(NS), .SEG_LEN(SL), .VARIANT(VAR_GATED)) u_seg_scan_chain_g (
    .clk_i(clk_i), .rst_ni(rst_ni), .test_en_i(test_en_i), .seg_en_i(seg_en_i),
    .scan_in_i(scan_in_i), .func_d_i(func_d_i), .cell_q_o(q_g), .scan_out_o(so_g));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  function automatic logic [SL-1:0] rotl(input logic [SL-1:0] v, input int n);
    logic [SL-1:0] r = v;
    for (int i = 0; i < n; i++) r = {r[SL-2:0], r[SL-1]};
    return r;
  endfunction

  task automatic capture(input logic [N-1:0] d, input logic [NS-1:0] en);
    test_en_i = 1'b0;
    seg_en_i  = en;
    func_d_i  = d;
    step();
  endtask

  task automatic t_reset();
    check("R1 cells fb", 64'(q_fb), 64'd0);
    check("R1 cells g", 64'(q_g), 64'd0);
  endtask

  task automatic t_capture();
    capture(32'hA5C3_1E77, 4'b1111);
    check("R2 capture fb", 64'(q_fb), 64'hA5C3_1E77);
    check("R2 capture g", 64'(q_g), 64'hA5C3_1E77);
    capture(32'h0F0F_5A3C, 4'b0000);
    check("R2 capture no-en fb", 64'(q_fb), 64'h0F0F_5A3C);
    check("R2 capture no-en g", 64'(q_g), 64'h0F0F_5A3C);
  endtask

  // load segment 2 with a byte; cell c ends with bit fed at step SL-1-c
  task automatic t_load_seg();
    logic [N-1:0] exp;
    logic [SL-1:0] b = 8'hD2;
    capture(32'h1234_5678, 4'b0000);
    test_en_i = 1'b1;
    seg_en_i  = 4'b0100;
    for (int i = 0; i < SL; i++) begin
      scan_in_i = b[SL-1-i];
      step();
    end
    exp = 32'h1234_5678;
    exp[2*SL +: SL] = b;
    check("R3 R8 load fb", 64'(q_fb), 64'(exp));
    check("R3 R5 load g", 64'(q_g), 64'(exp));
    check("R4 full recirc restores", 64'(q_fb & 32'hFF00_FFFF), 64'(32'h1234_5678 & 32'hFF00_FFFF));
  endtask

  task automatic t_partial();
    logic [N-1:0] f = 32'hA5C3_1E77;
    logic [N-1:0] exp_fb, exp_g;
    capture(f, 4'b0000);
    test_en_i = 1'b1;
    seg_en_i  = 4'b0001;
    scan_in_i = 1'b1;
    for (int i = 0; i < 3; i++) step();
    exp_fb = f;
    exp_g  = f;
    exp_fb[0 +: SL] = {f[4:0], 3'b111};
    exp_g[0 +: SL]  = {f[4:0], 3'b111};
    for (int s = 1; s < NS; s++) exp_fb[s*SL +: SL] = rotl(f[s*SL +: SL], 3);
    check("R3 partial enabled seg", 64'(q_fb[0 +: SL]), 64'(exp_fb[0 +: SL]));
    check("R4 partial recirc", 64'(q_fb), 64'(exp_fb));
    check("R5 partial hold", 64'(q_g), 64'(exp_g));
  endtask

  task automatic t_no_enable();
    logic [N-1:0] f = 32'h3C96_E1B4;
    logic [N-1:0] exp_fb;
    capture(f, 4'b0000);
    test_en_i = 1'b1;
    seg_en_i  = 4'b0000;
    scan_in_i = 1'b1;
    #1;
    check("R6 no enable so fb", 64'(so_fb), 64'd0);
    check("R6 no enable so g", 64'(so_g), 64'd0);
    step();
    for (int s = 0; s < NS; s++) exp_fb[s*SL +: SL] = rotl(f[s*SL +: SL], 1);
    check("R4 idle rotate", 64'(q_fb), 64'(exp_fb));
    check("R5 idle hold", 64'(q_g), 64'(f));
  endtask

  task automatic t_permute();
    logic [N-1:0] p = 32'h9E37_4C1B;
    logic [N-1:0] q = 32'h61D4_A8F3;
    int ord[NS] = '{2, 0, 3, 1};
    logic [N-1:0] got_fb, got_g, exp_stream;
    int k = 0;
    int bad = 0;
    capture(p, 4'b0000);
    test_en_i = 1'b1;
    for (int o = 0; o < NS; o++) begin
      int s = ord[o];
      seg_en_i = NS'(1) << s;
      for (int i = 0; i < SL; i++) begin
        scan_in_i = q[s*SL + SL-1-i];
        #1;
        got_fb[N-1-k]     = so_fb;
        got_g[N-1-k]      = so_g;
        exp_stream[N-1-k] = p[s*SL + SL-1-i];
        if (so_fb !== p[s*SL + SL-1-i]) bad++;
        k++;
        step();
      end
    end
    check("R6 per-bit tail routing", 64'(bad), 64'd0);
    check("R7 unload stream fb", 64'(got_fb), 64'(exp_stream));
    check("R7 unload stream g", 64'(got_g), 64'(exp_stream));
    check("R7 new pattern fb", 64'(q_fb), 64'(q));
    check("R7 new pattern g", 64'(q_g), 64'(q));
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #9;
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_capture();
    t_load_seg();
    t_partial();
    t_no_enable();
    t_permute();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule